// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds the delivery state of a bank of interrupt sources. Each source is fixed at build time as either edge-type, where a one-cycle event requests a single delivery, or level-type, where an input line is tracked. Every source keeps a target server, a delivery priority, a saved priority and four status flags: line-high, in-flight, bounced and held-while-masked. A priority of 0xFF means the source is masked. The flags make sure that a delivery that was masked, bounced by the presenter or never completed is offered again later.

Deliveries leave the block as offers of (server, global source number, priority) on a valid/ready channel, one at a time. The presenter talks back with two messages, each carrying a global source number: a bounce, which means the offer was refused, and an end-of-service. A resend request starts a walk across all sources in ascending index order, one source per cycle, and a done pulse marks the end of the walk. Software-style configuration writes set the server and both priorities of one source.

Requests raised in the same cycle, or while the channel is busy, wait in a per-source pending bit. The lowest-numbered pending source is offered first. The server and priority in an offer are the values stored at the moment the offer is loaded.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset no offer is valid, `scan_done` is low, and every source has priority 0xFF (masked) and saved priority 0xFF, so an edge event on any source produces no offer.
- R2: An edge event on an edge-type source whose priority is not 0xFF raises exactly one offer carrying that source's server, its priority and global number BASE + index. With the channel free, `offer_valid` rises in the second cycle after the event is sampled.
- R3: An edge event on an edge-type source at priority 0xFF produces no offer and marks the source held-while-masked. A later configuration write to that source with a priority other than 0xFF clears the mark and raises one offer. A held-while-masked source always has priority 0xFF.
- R4: A change on a level-type input updates the line-high flag. If the line is high, the priority is not 0xFF and the in-flight flag is clear, the block sets in-flight and raises one offer. While in-flight is set, no further offer is made for that source.
- R5: A bounce aimed at an edge-type source marks it bounced, with no immediate offer. The next resend walk clears the mark and offers the source again, or offers nothing if its priority is then 0xFF.
- R6: A bounce aimed at a level-type source clears in-flight, with no immediate offer. The next resend walk offers the source again if its line is still high.
- R7: An end-of-service message clears in-flight on a level-type source, and the next resend walk then offers it again if its line is still high. On an edge-type source the message has no effect, so a following walk offers nothing.
- R8: A configuration write updates the server, priority and saved priority of the selected source and then, for a level-type source, runs the level delivery check of R4. The saved priority changes only on a write.
- R9: Bounce and end-of-service messages are matched by subtracting BASE from their global number. Numbers below BASE or at or above BASE + NUM_SRC are ignored.
- R10: An offer holds its server, number and priority while `offer_valid` is high and `offer_ready` is low. When several sources are pending, the lowest index is offered first.
- R11: A resend request sampled while no walk runs starts a walk that visits indices 0 to NUM_SRC-1, one per cycle. `scan_done` is high for one cycle, NUM_SRC cycles after the request is sampled. A request sampled during a walk is ignored.
- R12: Reset clears all status flags and pending requests but keeps each source's edge/level type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| edge_evt | input | NUM_SRC | One-cycle event per edge-type source |
| lvl_in | input | NUM_SRC | Line value per level-type source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local index to configure |
| cfg_server | input | SRV_W | New target server |
| cfg_prio | input | 8 | New priority (0xFF masks) |
| cfg_saved_prio | input | 8 | New saved priority |
| rej_vld | input | 1 | Bounce message strobe |
| rej_gsn | input | GSN_W | Global number of the bounced source |
| eoi_vld | input | 1 | End-of-service message strobe |
| eoi_gsn | input | GSN_W | Global number of the serviced source |
| resend_req | input | 1 | Start a resend walk |
| offer_valid | output | 1 | Offer present |
| offer_ready | input | 1 | Presenter takes the offer |
| offer_server | output | SRV_W | Target server of the offer |
| offer_gsn | output | GSN_W | Global source number of the offer |
| offer_prio | output | 8 | Priority of the offer |
| scan_done | output | 1 | One-cycle pulse at the end of a resend walk |

## Verification
A behavioural model of the sources is compared with the offer channel and the done pulse on every cycle. The directed patterns are chosen so that each one separates a specific pair of behaviours. Edge events at masked and unmasked priority separate held-while-masked replay from direct offers. Bounce and end-of-service messages are sent to both source types, so that a walk afterwards shows which flag each one touched. Simultaneous events with `offer_ready` held low expose the ordering and hold rules. Out-of-range message numbers that alias index 0 in their low bits, a resend request repeated mid-walk, and a reset taken while lines are high show that range checks, walk exclusivity and type retention hold.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
  typedef logic [7:0] prio_t;
  localparam prio_t PRIO_MASKED = 8'hFF;
endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
  import irq_src_pkg::*;
#(
  parameter int SRV_W    = 4,
  parameter bit IS_LEVEL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  input  logic             lvl_i,
  input  logic             cfg_hit_i,
  input  logic [SRV_W-1:0] cfg_srv_i,
  input  prio_t            cfg_prio_i,
  input  prio_t            cfg_saved_i,
  input  logic             rej_i,
  input  logic             eoi_i,
  input  logic             visit_i,
  input  logic             grant_i,
  output logic             want_o,
  output logic [SRV_W-1:0] srv_o,
  output prio_t            prio_o
);
  logic [SRV_W-1:0] srv_q, srv_d;
  prio_t prio_q, prio_d, saved_q, saved_d;
  logic asrt_q, asrt_d, sent_q, sent_d, bnc_q, bnc_d, mpend_q, mpend_d;
  logic want_q, want_d, lvl_trig;

  always_comb begin
    srv_d   = srv_q;
    prio_d  = prio_q;
    saved_d = saved_q;
    asrt_d  = asrt_q;
    sent_d  = sent_q;
    bnc_d   = bnc_q;
    mpend_d = mpend_q;
    want_d  = want_q & ~grant_i;
    lvl_trig = 1'b0;
    // line / event input
    if (IS_LEVEL) begin
      if (lvl_i != asrt_q) begin
        asrt_d   = lvl_i;
        lvl_trig = 1'b1;
      end
    end else if (edge_i) begin
      if (prio_q == PRIO_MASKED) mpend_d = 1'b1;
      else                       want_d  = 1'b1;
    end
    // configuration write
    if (cfg_hit_i) begin
      srv_d   = cfg_srv_i;
      prio_d  = cfg_prio_i;
      saved_d = cfg_saved_i;
      if (IS_LEVEL) lvl_trig = 1'b1;
      else if (mpend_d && cfg_prio_i != PRIO_MASKED) begin
        mpend_d = 1'b0;
        want_d  = 1'b1;
      end
    end
    // presenter messages
    if (rej_i) begin
      if (IS_LEVEL) sent_d = 1'b0;
      else          bnc_d  = 1'b1;
    end
    if (eoi_i && IS_LEVEL) sent_d = 1'b0;
    // resend walk visit
    if (visit_i) begin
      if (IS_LEVEL) lvl_trig = 1'b1;
      else if (bnc_d) begin
        bnc_d = 1'b0;
        if (prio_d != PRIO_MASKED) want_d = 1'b1;
      end
    end
    // level delivery check
    if (IS_LEVEL && lvl_trig && prio_d != PRIO_MASKED && asrt_d && !sent_d) begin
      sent_d = 1'b1;
      want_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srv_q   <= '0;
      prio_q  <= PRIO_MASKED;
      saved_q <= PRIO_MASKED;
      asrt_q  <= 1'b0;
      sent_q  <= 1'b0;
      bnc_q   <= 1'b0;
      mpend_q <= 1'b0;
      want_q  <= 1'b0;
    end else begin
      srv_q   <= srv_d;
      prio_q  <= prio_d;
      saved_q <= saved_d;
      asrt_q  <= asrt_d;
      sent_q  <= sent_d;
      bnc_q   <= bnc_d;
      mpend_q <= mpend_d;
      want_q  <= want_d;
    end
  end

  assign want_o = want_q;
  assign srv_o  = srv_q;
  assign prio_o = prio_q;

  p_mpend_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mpend_q |-> prio_q == PRIO_MASKED);
  p_sent_offers_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sent_q) |-> want_q);
  p_saved_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_hit_i |=> $stable(saved_q));
endmodule

// File: rtl/irq_offer_arb.sv
module irq_offer_arb
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SRV_W   = 4,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0]              want_i,
  input  logic [NUM_SRC-1:0][SRV_W-1:0]   srv_i,
  input  logic [NUM_SRC-1:0][7:0]         prio_i,
  input  logic                            ready_i,
  output logic [NUM_SRC-1:0]              grant_o,
  output logic                            vld_o,
  output logic [IDX_W-1:0]                idx_o,
  output logic [SRV_W-1:0]                srv_o,
  output prio_t                           prio_o
);
  logic             vld_q, load;
  logic [IDX_W-1:0] idx_q, pick;
  logic [SRV_W-1:0] srv_q;
  prio_t            prio_q;

  always_comb begin
    pick = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (want_i[i]) pick = IDX_W'(i);
    end
  end

  assign load = (|want_i) && (!vld_q || ready_i);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_grant
    assign grant_o[g] = load && (pick == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      idx_q  <= '0;
      srv_q  <= '0;
      prio_q <= '0;
    end else if (load) begin
      vld_q  <= 1'b1;
      idx_q  <= pick;
      srv_q  <= srv_i[pick];
      prio_q <= prio_i[pick];
    end else if (ready_i) begin
      vld_q <= 1'b0;
    end
  end

  assign vld_o  = vld_q;
  assign idx_o  = idx_q;
  assign srv_o  = srv_q;
  assign prio_o = prio_q;

  p_grant_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  p_grant_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & ~want_i) == '0);
  p_offer_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q && !ready_i |=> vld_q && $stable(idx_q) && $stable(srv_q) && $stable(prio_q));
endmodule

// File: rtl/irq_resend_walk.sv
module irq_resend_walk #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int LAST   = NUM_SRC - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  output logic [NUM_SRC-1:0] visit_o,
  output logic               done_o
);
  logic             busy_q, done_q, at_last;
  logic [IDX_W-1:0] ptr_q;

  assign at_last = busy_q && (ptr_q == IDX_W'(LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= at_last;
      if (busy_q) begin
        if (at_last) busy_q <= 1'b0;
        else         ptr_q  <= ptr_q + 1'b1;
      end else if (start_i) begin
        busy_q <= 1'b1;
        ptr_q  <= '0;
      end
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_visit
    assign visit_o[g] = busy_q && (ptr_q == IDX_W'(g));
  end
  assign done_o = done_q;

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  p_walk_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !at_last |=> busy_q && ptr_q == $past(ptr_q) + 1'b1);
endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
  import irq_src_pkg::*;
#(
  parameter int               NUM_SRC   = 8,
  parameter int               SRV_W     = 4,
  parameter int               GSN_W     = 16,
  parameter int               BASE      = 256,
  parameter logic [NUM_SRC-1:0] LEVEL_MAP = 8'hF0,
  localparam int              IDX_W     = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] edge_evt,
  input  logic [NUM_SRC-1:0] lvl_in,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [SRV_W-1:0]   cfg_server,
  input  logic [7:0]         cfg_prio,
  input  logic [7:0]         cfg_saved_prio,
  input  logic               rej_vld,
  input  logic [GSN_W-1:0]   rej_gsn,
  input  logic               eoi_vld,
  input  logic [GSN_W-1:0]   eoi_gsn,
  input  logic               resend_req,
  output logic               offer_valid,
  input  logic               offer_ready,
  output logic [SRV_W-1:0]   offer_server,
  output logic [GSN_W-1:0]   offer_gsn,
  output logic [7:0]         offer_prio,
  output logic               scan_done
);
  localparam logic [GSN_W-1:0] BASE_G = GSN_W'(BASE);
  localparam logic [GSN_W:0]   LO_X   = (GSN_W+1)'(BASE);
  localparam logic [GSN_W:0]   HI_X   = (GSN_W+1)'(BASE + NUM_SRC);

  // global number -> one-hot local slot, empty when out of range
  function automatic logic [NUM_SRC-1:0] gsn_decode(input logic v, input logic [GSN_W-1:0] g);
    logic [GSN_W-1:0] loc;
    logic             inr;
    loc = g - BASE_G;
    inr = ({1'b0, g} >= LO_X) && ({1'b0, g} < HI_X);
    for (int i = 0; i < NUM_SRC; i++) begin
      gsn_decode[i] = v && inr && (loc == GSN_W'(i));
    end
  endfunction

  function automatic logic [GSN_W-1:0] idx_to_gsn(input logic [IDX_W-1:0] idx);
    return BASE_G + GSN_W'(idx);
  endfunction

  logic [NUM_SRC-1:0] rej_hit, eoi_hit, cfg_hit, visit, want, grant;
  logic [NUM_SRC-1:0][SRV_W-1:0] slot_srv;
  logic [NUM_SRC-1:0][7:0]       slot_prio;
  logic [IDX_W-1:0]              off_idx;

  assign rej_hit = gsn_decode(rej_vld, rej_gsn);
  assign eoi_hit = gsn_decode(eoi_vld, eoi_gsn);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
    assign cfg_hit[g] = cfg_we && (cfg_idx == IDX_W'(g));
    irq_src_slot #(.SRV_W(SRV_W), .IS_LEVEL(LEVEL_MAP[g])) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .edge_i     (edge_evt[g]),
      .lvl_i      (lvl_in[g]),
      .cfg_hit_i  (cfg_hit[g]),
      .cfg_srv_i  (cfg_server),
      .cfg_prio_i (cfg_prio),
      .cfg_saved_i(cfg_saved_prio),
      .rej_i      (rej_hit[g]),
      .eoi_i      (eoi_hit[g]),
      .visit_i    (visit[g]),
      .grant_i    (grant[g]),
      .want_o     (want[g]),
      .srv_o      (slot_srv[g]),
      .prio_o     (slot_prio[g])
    );
  end

  irq_offer_arb #(.NUM_SRC(NUM_SRC), .SRV_W(SRV_W)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .want_i (want),
    .srv_i  (slot_srv),
    .prio_i (slot_prio),
    .ready_i(offer_ready),
    .grant_o(grant),
    .vld_o  (offer_valid),
    .idx_o  (off_idx),
    .srv_o  (offer_server),
    .prio_o (offer_prio)
  );

  irq_resend_walk #(.NUM_SRC(NUM_SRC)) u_walk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(resend_req),
    .visit_o(visit),
    .done_o (scan_done)
  );

  assign offer_gsn = idx_to_gsn(off_idx);

  p_offer_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid |-> ({1'b0, offer_gsn} >= LO_X) && ({1'b0, offer_gsn} < HI_X));
  p_msg_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rej_hit) && $onehot0(eoi_hit));
endmodule

// File: tb/tb_irq_src_ctrl.sv
module tb_irq_src_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 8;
  localparam int BASE = 256;
  localparam logic [7:0] LVL_MAP = 8'hF0;

  logic clk = 0, rst_n = 0;
  logic [7:0] edge_evt = 0, lvl_in = 0;
  logic cfg_we = 0; logic [2:0] cfg_idx = 0; logic [3:0] cfg_server = 0;
  logic [7:0] cfg_prio = 0, cfg_saved_prio = 0;
  logic rej_vld = 0, eoi_vld = 0, resend_req = 0, offer_ready = 1;
  logic [15:0] rej_gsn = 0, eoi_gsn = 0;
  logic offer_valid, scan_done; logic [3:0] offer_server;
  logic [15:0] offer_gsn; logic [7:0] offer_prio;

  int n_cmp = 0, n_bad = 0;

  irq_src_ctrl #(.NUM_SRC(NSRC), .SRV_W(4), .GSN_W(16), .BASE(BASE), .LEVEL_MAP(LVL_MAP)) dut (
    .clk(clk), .rst_n(rst_n), .edge_evt(edge_evt), .lvl_in(lvl_in), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_server(cfg_server), .cfg_prio(cfg_prio),
    .cfg_saved_prio(cfg_saved_prio), .rej_vld(rej_vld), .rej_gsn(rej_gsn),
    .eoi_vld(eoi_vld), .eoi_gsn(eoi_gsn), .resend_req(resend_req),
    .offer_valid(offer_valid), .offer_ready(offer_ready), .offer_server(offer_server),
    .offer_gsn(offer_gsn), .offer_prio(offer_prio), .scan_done(scan_done));

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int m_prio[NSRC], m_srv[NSRC];
  bit m_asrt[NSRC], m_sent[NSRC], m_bnc[NSRC], m_mp[NSRC], m_want[NSRC];
  bit m_vld, m_busy, m_done;
  int m_gsn, m_osrv, m_oprio, m_ptr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        m_prio[i] = 255; m_srv[i] = 0; m_asrt[i] = 0; m_sent[i] = 0;
        m_bnc[i] = 0; m_mp[i] = 0; m_want[i] = 0;
      end
      m_vld = 0; m_busy = 0; m_done = 0; m_gsn = BASE; m_osrv = 0; m_oprio = 0; m_ptr = 0;
    end else begin
      int pick; pick = -1;
      for (int i = 0; i < NSRC; i++) if (m_want[i] && pick < 0) pick = i;
      if (!m_vld || offer_ready) begin
        if (pick >= 0) begin
          m_vld = 1; m_gsn = BASE + pick; m_osrv = m_srv[pick]; m_oprio = m_prio[pick];
          m_want[pick] = 0;
        end else m_vld = 0;
      end
      for (int i = 0; i < NSRC; i++) begin
        bit lv, trig;
        lv = LVL_MAP[i]; trig = 0;
        if (lv) begin
          if (lvl_in[i] != m_asrt[i]) begin m_asrt[i] = lvl_in[i]; trig = 1; end
        end else if (edge_evt[i]) begin
          if (m_prio[i] == 255) m_mp[i] = 1; else m_want[i] = 1;
        end
        if (cfg_we && cfg_idx == i) begin
          m_srv[i] = cfg_server; m_prio[i] = cfg_prio;
          if (lv) trig = 1;
          else if (m_mp[i] && cfg_prio != 255) begin m_mp[i] = 0; m_want[i] = 1; end
        end
        if (rej_vld && rej_gsn == BASE + i) begin
          if (lv) m_sent[i] = 0; else m_bnc[i] = 1;
        end
        if (eoi_vld && eoi_gsn == BASE + i && lv) m_sent[i] = 0;
        if (m_busy && m_ptr == i) begin
          if (lv) trig = 1;
          else if (m_bnc[i]) begin m_bnc[i] = 0; if (m_prio[i] != 255) m_want[i] = 1; end
        end
        if (lv && trig && m_prio[i] != 255 && m_asrt[i] && !m_sent[i]) begin
          m_sent[i] = 1; m_want[i] = 1;
        end
      end
      m_done = m_busy && m_ptr == NSRC - 1;
      if (m_busy) begin
        if (m_ptr == NSRC - 1) m_busy = 0; else m_ptr++;
      end else if (resend_req) begin
        m_busy = 1; m_ptr = 0;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      n_cmp++;
      if (offer_valid !== m_vld ||
          (m_vld && (offer_gsn != m_gsn || offer_server != m_osrv || offer_prio != m_oprio))) begin
        n_bad++;
        $display("FAIL R10 offer channel: actual v=%0b gsn=%0h srv=%0d prio=%0h expected v=%0b gsn=%0h srv=%0d prio=%0h",
                 offer_valid, offer_gsn, offer_server, offer_prio, m_vld, m_gsn, m_osrv, m_oprio);
      end
      n_cmp++;
      if (scan_done !== m_done) begin
        n_bad++;
        $display("FAIL R11 scan_done: actual %0b expected %0b", scan_done, m_done);
      end
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input int srv, input int prio);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_server = 4'(srv); cfg_prio = 8'(prio);
    cfg_saved_prio = 8'(prio ^ 8'h0F);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic edge_ev(input logic [7:0] m);
    edge_evt = m; @(negedge clk); edge_evt = 0;
  endtask

  task automatic bounce(input int g);
    rej_vld = 1; rej_gsn = 16'(g); @(negedge clk); rej_vld = 0;
  endtask

  task automatic serviced(input int g);
    eoi_vld = 1; eoi_gsn = 16'(g); @(negedge clk); eoi_vld = 0;
  endtask

  task automatic resend();
    resend_req = 1; @(negedge clk); resend_req = 0;
  endtask

  task automatic expect_offer(input int g, input int srv, input int prio, input string tag);
    int w; w = 0;
    while (!offer_valid && w < 16) begin @(negedge clk); w++; end
    check(offer_valid && offer_gsn == g && offer_server == srv && offer_prio == prio,
          tag, offer_valid ? int'(offer_gsn) : -1, g);
    @(negedge clk);
  endtask

  task automatic expect_quiet(input int n, input string tag);
    int seen; seen = -1;
    for (int k = 0; k < n; k++) begin
      if (offer_valid && seen < 0) seen = offer_gsn;
      @(negedge clk);
    end
    check(seen < 0, tag, seen, -1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!offer_valid && !scan_done, "R1 reset outputs", {offer_valid, scan_done}, 0);
    edge_ev(8'h01);                        // masked after reset
    expect_quiet(6, "R1 masked after reset");
    cfg(0, 3, 5);
    expect_offer(BASE + 0, 3, 5, "R3 release of held event");
    cfg(1, 2, 'h10);
    edge_ev(8'h02);
    expect_offer(BASE + 1, 2, 'h10, "R2 edge offer");
    cfg(2, 4, 'h20); cfg(3, 5, 'h30);
    edge_ev(8'h0C);
    expect_offer(BASE + 2, 4, 'h20, "R10 lowest first");
    expect_offer(BASE + 3, 5, 'h30, "R2 second pending");
    // edge bounce and replay
    bounce(BASE + 1);
    expect_quiet(4, "R5 no immediate offer");
    resend();
    expect_offer(BASE + 1, 2, 'h10, "R5 replay on walk");
    expect_quiet(12, "R5 single replay");
    bounce(BASE + 1);
    cfg(1, 2, 255);
    resend();
    expect_quiet(14, "R5 masked bounce dropped");
    cfg(1, 2, 'h10);
    expect_quiet(6, "R5 bounce mark cleared");
    // level source
    cfg(4, 1, 7);
    expect_quiet(4, "R8 level low no offer");
    lvl_in[4] = 1;
    expect_offer(BASE + 4, 1, 7, "R4 level offer");
    expect_quiet(4, "R4 in-flight blocks");
    resend();
    expect_quiet(12, "R4 walk while in-flight");
    serviced(BASE + 4);
    expect_quiet(4, "R7 service no offer");
    resend();
    expect_offer(BASE + 4, 1, 7, "R7 level replay after service");
    bounce(BASE + 4);
    expect_quiet(4, "R6 bounce no offer");
    resend();
    expect_offer(BASE + 4, 1, 7, "R6 level replay after bounce");
    expect_quiet(12, "R6 walk end");
    serviced(BASE + 2);                    // edge source
    resend();
    expect_quiet(14, "R7 service on edge ignored");
    lvl_in[5] = 1;
    expect_quiet(4, "R4 masked level");
    cfg(5, 6, 3);
    expect_offer(BASE + 5, 6, 3, "R8 write runs level check");
    bounce(BASE + 8); bounce(BASE - 8);    // alias index 0 in low bits
    resend();
    expect_quiet(14, "R9 out-of-range ignored");
    // hold under back-pressure
    offer_ready = 0;
    edge_ev(8'h03);
    expect_quiet(1, "R10 pre");
    check(offer_valid && offer_gsn == BASE, "R10 first offered", offer_gsn, BASE);
    repeat (3) @(negedge clk);
    check(offer_valid && offer_gsn == BASE && offer_prio == 5, "R10 held", offer_gsn, BASE);
    offer_ready = 1;
    @(negedge clk);
    expect_offer(BASE + 1, 2, 'h10, "R10 next after release");
    // walk timing and repeated request
    begin
      int n, dones;
      resend(); n = 1; dones = 0;
      while (!scan_done && n < 3 * NSRC) begin
        if (n == 2) resend_req = 1; else resend_req = 0;
        @(negedge clk); n++;
      end
      resend_req = 0;
      check(n == NSRC + 1, "R11 done latency", n, NSRC + 1);
      for (int k = 0; k < 2 * NSRC; k++) begin @(negedge clk); if (scan_done) dones++; end
      check(dones == 0, "R11 repeat ignored", dones, 0);
    end
    // reset keeps type
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    edge_ev(8'h01);
    expect_quiet(6, "R12 status cleared");
    cfg(5, 9, 2);
    expect_offer(BASE + 5, 9, 2, "R12 level type kept");
    cfg(0, 1, 2);
    expect_offer(BASE + 0, 1, 2, "R12 edge held after reset");
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule